// File: doc/BRIEF.md
# Reset Source Sequencer and Classifier

This block owns the reset of a small processor core. It gathers four reasons to reset: the power-on event (its own active-low reset input), an active-low reset pin shared with the board, a timeout flag from a watchdog, and a failure flag from a clock-loss detector. It holds the core in reset and drives the shared pin through an open-drain pull-down enable. It also tells the core which of three reset vectors to fetch once reset ends.

After power-on it waits for the oscillator to report activity. It then keeps the core in reset for a long settling delay and, if the board is still holding the pin low, for as long as that lasts. This path never pulls the pin. Any other reset pulls the pin low for a short fixed window, lets it go, and reads it back a fixed time later through a two-flop synchronizer. A pin still low then means the board is asserting reset, so the reset is taken as external. A pin that has come back high means the reset came from inside, and the latched internal flag picks the vector.

Top module: `rst_seq_top`

## Requirements
- R1: While `porN` is low, `coreRst` is 1, `pinDriveLow` is 0 and `vecSel` is 2'b00.
- R2: After `porN` rises, `coreRst` stays 1 for as long as `oscReady` is 0. When `oscReady` is high and the pin is high, `coreRst` falls at the rising edge numbered POR_CYCLES+1, counting the first edge that samples `oscReady` high as number 1.
- R3: If the pin is still low when the power-on delay ends, `coreRst` stays 1. It falls at the third rising edge after the pin goes high, because of the two synchronizer flops and one state update.
- R4: The power-on sequence never sets `pinDriveLow`.
- R5: Out of reset, a high `wdogFlag` or `clkFailFlag` on one rising edge, or a synchronized low pin, starts a sequence. `coreRst` rises after that edge, and `pinDriveLow` is 1 for exactly DRIVE_CYCLES cycles, starting the same cycle.
- R6: If the synchronized pin is high SAMPLE_GAP+2 cycles after the drive ends, `coreRst` falls on the next cycle. The whole reset then lasts DRIVE_CYCLES+SAMPLE_GAP+2 cycles without a break.
- R7: If the pin is sampled low, the reset counts as external. `vecSel` becomes 2'b00 even if an internal flag was latched, and `coreRst` stays 1 until the third rising edge after the pin goes high.
- R8: The `vecSel` codes are: 2'b00 normal (power-on or pin), 2'b01 clock failure, 2'b10 watchdog. If both internal flags are seen together, clock failure wins. The code 2'b11 never appears.
- R9: The internal flags are latched on the edge that starts a sequence. Flags raised later during that reset are ignored. For an internal reset, `vecSel` stays constant for the whole time `coreRst` is 1, and it is 2'b00 whenever `coreRst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one cycle per bus cycle |
| porN | input | 1 | Power-on reset, active low, asynchronous assert |
| oscReady | input | 1 | Oscillator reports stable activity |
| pinIn | input | 1 | Level read back from the shared reset pin |
| wdogFlag | input | 1 | Watchdog timeout flag |
| clkFailFlag | input | 1 | Clock-loss detector flag |
| coreRst | output | 1 | Reset to the core, active high |
| pinDriveLow | output | 1 | Enable for the open-drain pull-down on the pin |
| vecSel | output | 2 | Reset vector selection for the core |

## Verification
The bench builds the block with POR_CYCLES=16, DRIVE_CYCLES=4 and SAMPLE_GAP=2. The short settling delay lets both power-on cases be run to completion: one with the pin high when the delay ends, and one with the pin still held low. The drive and sample windows keep their default size, so the reset length of DRIVE_CYCLES+SAMPLE_GAP+2 is checked exactly. The pin is modelled as a wired level from the drive enable and a board-side hold. This makes self-driven, board-held and mixed-cause resets all reachable.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWR   = 3'd0,
    ST_POR   = 3'd1,
    ST_HOLD  = 3'd2,
    ST_IDLE  = 3'd3,
    ST_DRIVE = 3'd4,
    ST_GAP   = 3'd5
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic latchFlags;
    logic clrFlags;
  } seqStrobe_t;

  localparam logic [1:0] VEC_NORMAL = 2'b00;
  localparam logic [1:0] VEC_CLKMON = 2'b01;
  localparam logic [1:0] VEC_WDOG   = 2'b10;

  localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/rst_seq_datapath.sv
module rst_seq_datapath
  import rst_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             pinIn,
  input  logic             wdogFlag,
  input  logic             clkFailFlag,
  input  seqStrobe_t       strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             pinSync,
  output logic [1:0]       vecSel
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   wdogSeen;
  logic                   clkFailSeen;

  // Two-flop synchronizer on the pin readback
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
  end
  assign pinSync = syncChain[SYNC_STAGES-1];

  // Shared window counter
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntEn)  cnt <= cnt + CNT_W'(1);
  end

  // Source latches: captured at sequence start, dropped on release or external verdict
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wdogSeen    <= 1'b0;
      clkFailSeen <= 1'b0;
    end else if (strobe.clrFlags) begin
      wdogSeen    <= 1'b0;
      clkFailSeen <= 1'b0;
    end else if (strobe.latchFlags) begin
      wdogSeen    <= wdogFlag;
      clkFailSeen <= clkFailFlag;
    end
  end

  always_comb begin
    if (clkFailSeen)   vecSel = VEC_CLKMON;
    else if (wdogSeen) vecSel = VEC_WDOG;
    else               vecSel = VEC_NORMAL;
  end

  // R8: the unused code never reaches the core
  a_r8_no_code3: assert property (@(posedge clk) disable iff (!porN)
    vecSel != 2'b11);

  // R9: a latch request never coincides with a clear request
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!porN)
    !(strobe.latchFlags && strobe.clrFlags));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int POR_CYCLES   = 4064,
  parameter int DRIVE_CYCLES = 4,
  parameter int GAP_TOTAL    = 4,
  parameter int CNT_W        = 12
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             oscReady,
  input  logic             pinSync,
  input  logic             wdogFlag,
  input  logic             clkFailFlag,
  input  logic [CNT_W-1:0] cnt,
  output seqStrobe_t       strobe,
  output logic             coreRst,
  output logic             pinDriveLow
);

  localparam logic [CNT_W-1:0] PorLast   = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] DriveLast = CNT_W'(DRIVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] GapLast   = CNT_W'(GAP_TOTAL - 1);

  seqState_t state;
  seqState_t stateNext;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_PWR;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_PWR: begin
        if (oscReady) begin
          stateNext     = ST_POR;
          strobe.cntClr = 1'b1;
        end
      end
      ST_POR: begin
        strobe.cntEn = 1'b1;
        if (cnt == PorLast) begin
          if (pinSync) begin
            stateNext       = ST_IDLE;
            strobe.clrFlags = 1'b1;
          end else begin
            stateNext = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (pinSync) begin
          stateNext       = ST_IDLE;
          strobe.clrFlags = 1'b1;
        end
      end
      ST_IDLE: begin
        if (!pinSync || wdogFlag || clkFailFlag) begin
          stateNext         = ST_DRIVE;
          strobe.cntClr     = 1'b1;
          strobe.latchFlags = 1'b1;
        end
      end
      ST_DRIVE: begin
        strobe.cntEn = 1'b1;
        if (cnt == DriveLast) begin
          stateNext     = ST_GAP;
          strobe.cntClr = 1'b1;
        end
      end
      ST_GAP: begin
        strobe.cntEn = 1'b1;
        if (cnt == GapLast) begin
          // High readback: internal cause, release next cycle.
          // Low readback: board is holding the pin, treat as external.
          stateNext       = pinSync ? ST_IDLE : ST_HOLD;
          strobe.clrFlags = 1'b1;
        end
      end
      default: stateNext = ST_PWR;
    endcase
  end

  assign coreRst     = (state != ST_IDLE);
  assign pinDriveLow = (state == ST_DRIVE);

  // R6/R7/R3: the core only leaves reset after a high synchronized readback
  a_r6_release_on_high: assert property (@(posedge clk) disable iff (!porN)
    $fell(coreRst) |-> $past(pinSync));

  // R5: the pin is only pulled while the core is held
  a_r5_drive_in_reset: assert property (@(posedge clk) disable iff (!porN)
    pinDriveLow |-> coreRst);

  // R6: a finished drive window is always followed by the sample wait, still in reset
  a_r6_gap_follows: assert property (@(posedge clk) disable iff (!porN)
    $fell(pinDriveLow) |-> coreRst);

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int POR_CYCLES   = 4064,
  parameter int DRIVE_CYCLES = 4,
  parameter int SAMPLE_GAP   = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       oscReady,
  input  logic       pinIn,
  input  logic       wdogFlag,
  input  logic       clkFailFlag,
  output logic       coreRst,
  output logic       pinDriveLow,
  output logic [1:0] vecSel
);

  localparam int GapTotal = SAMPLE_GAP + SYNC_STAGES;
  localparam int MaxCnt   = (POR_CYCLES > DRIVE_CYCLES) ?
                            ((POR_CYCLES > GapTotal) ? POR_CYCLES : GapTotal) :
                            ((DRIVE_CYCLES > GapTotal) ? DRIVE_CYCLES : GapTotal);
  localparam int CntW     = $clog2(MaxCnt + 1);

  seqStrobe_t        strobe;
  logic [CntW-1:0]   cnt;
  logic              pinSync;

  rst_seq_ctrl #(
    .POR_CYCLES  (POR_CYCLES),
    .DRIVE_CYCLES(DRIVE_CYCLES),
    .GAP_TOTAL   (GapTotal),
    .CNT_W       (CntW)
  ) u_ctrl (
    .clk        (clk),
    .porN       (porN),
    .oscReady   (oscReady),
    .pinSync    (pinSync),
    .wdogFlag   (wdogFlag),
    .clkFailFlag(clkFailFlag),
    .cnt        (cnt),
    .strobe     (strobe),
    .coreRst    (coreRst),
    .pinDriveLow(pinDriveLow)
  );

  rst_seq_datapath #(
    .CNT_W(CntW)
  ) u_dp (
    .clk        (clk),
    .porN       (porN),
    .pinIn      (pinIn),
    .wdogFlag   (wdogFlag),
    .clkFailFlag(clkFailFlag),
    .strobe     (strobe),
    .cnt        (cnt),
    .pinSync    (pinSync),
    .vecSel     (vecSel)
  );

  // R9: outside reset the core sees the normal vector
  a_r9_idle_vec: assert property (@(posedge clk) disable iff (!porN)
    !coreRst |-> vecSel == VEC_NORMAL);

  // R9: the vector does not move while the pin is being pulled
  a_r9_vec_stable_drive: assert property (@(posedge clk) disable iff (!porN)
    (pinDriveLow && $past(pinDriveLow)) |-> $stable(vecSel));

endmodule

// File: tb/rst_seq_top_tb.sv
module rst_seq_top_tb;

  localparam int POR_N = 16;
  localparam int DRV_N = 4;
  localparam int GAP_N = 2;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic oscReady = 1'b0;
  logic wdogFlag = 1'b0;
  logic clkFailFlag = 1'b0;
  logic extLow = 1'b0;
  logic pinIn;
  logic coreRst;
  logic pinDriveLow;
  logic [1:0] vecSel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign pinIn = ~(pinDriveLow | extLow);

  rst_seq_top #(
    .POR_CYCLES  (POR_N),
    .DRIVE_CYCLES(DRV_N),
    .SAMPLE_GAP  (GAP_N)
  ) u_dut (
    .clk        (clk),
    .porN       (porN),
    .oscReady   (oscReady),
    .pinIn      (pinIn),
    .wdogFlag   (wdogFlag),
    .clkFailFlag(clkFailFlag),
    .coreRst    (coreRst),
    .pinDriveLow(pinDriveLow),
    .vecSel     (vecSel)
  );

  typedef struct {
    logic [1:0] vec;
    int         len;   // 0: not checked
    int         drv;   // expected pull-down cycles
    bit         stab;  // vector must hold for the whole reset
  } expItem_t;

  expItem_t expQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_reset(input logic [1:0] v, input int len, input int drv, input bit stab);
    expItem_t it;
    it.vec = v; it.len = len; it.drv = drv; it.stab = stab;
    expQ.push_back(it);
  endtask

  // Monitor: measures each reset episode and compares with the queue head
  bit         inRst = 1'b1;
  int         rstLen = 0;
  int         drvLen = 0;
  bit         vecMoved = 1'b0;
  logic [1:0] lastVec = 2'b00;

  always @(negedge clk) begin
    if (!porN) begin
      inRst = 1'b1; rstLen = 0; drvLen = 0; vecMoved = 1'b0; lastVec = vecSel;
    end else if (coreRst) begin
      if (!inRst) begin
        inRst = 1'b1; rstLen = 0; drvLen = 0; vecMoved = 1'b0; lastVec = vecSel;
      end
      rstLen++;
      if (pinDriveLow) drvLen++;
      if (vecSel !== lastVec) vecMoved = 1'b1;
      lastVec = vecSel;
    end else if (inRst) begin
      inRst = 1'b0;
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected reset episode", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(lastVec == it.vec, "R8 vector at release", int'(lastVec), int'(it.vec));
        check(drvLen == it.drv, "R4/R5 pull-down length", drvLen, it.drv);
        if (it.len != 0) check(rstLen == it.len, "R6 reset length", rstLen, it.len);
        if (it.stab) check(!vecMoved, "R9 vector stable in reset", int'(vecMoved), 0);
      end
    end
  end

  task automatic wait_release();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!coreRst) break;
    end
  endtask

  task automatic pulse(input bit w, input bit c);
    @(negedge clk);
    wdogFlag = w; clkFailFlag = c;
    @(negedge clk);
    wdogFlag = 1'b0; clkFailFlag = 1'b0;
    wait_release();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(coreRst == 1'b1, "R1 coreRst in power-on", int'(coreRst), 1);
    check(pinDriveLow == 1'b0, "R1 pinDriveLow in power-on", int'(pinDriveLow), 0);
    check(vecSel == 2'b00, "R1 vecSel in power-on", int'(vecSel), 0);

    // R2: held until oscillator active, then POR_N+1 edges
    expect_reset(2'b00, 0, 0, 1'b1);
    porN = 1'b1;
    repeat (10) @(negedge clk);
    check(coreRst == 1'b1, "R2 held without oscillator", int'(coreRst), 1);
    oscReady = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (!coreRst) break;
    end
    check(n == POR_N + 1, "R2 power-on delay edges", n, POR_N + 1);
    repeat (3) @(negedge clk);

    // R5 R6 R8: watchdog -> 2'b10
    expect_reset(2'b10, DRV_N + GAP_N + 2, DRV_N, 1'b1);
    pulse(1'b1, 1'b0);
    // R8: clock failure -> 2'b01
    expect_reset(2'b01, DRV_N + GAP_N + 2, DRV_N, 1'b1);
    pulse(1'b0, 1'b1);
    // R8: both together, clock failure wins
    expect_reset(2'b01, DRV_N + GAP_N + 2, DRV_N, 1'b1);
    pulse(1'b1, 1'b1);

    // R9: a later flag during the reset is ignored
    expect_reset(2'b10, DRV_N + GAP_N + 2, DRV_N, 1'b1);
    @(negedge clk); wdogFlag = 1'b1;
    @(negedge clk); wdogFlag = 1'b0;
    @(negedge clk); clkFailFlag = 1'b1;
    @(negedge clk); clkFailFlag = 1'b0;
    wait_release();
    repeat (3) @(negedge clk);

    // R7: board holds the pin -> external, vector 00
    expect_reset(2'b00, 0, DRV_N, 1'b1);
    @(negedge clk); extLow = 1'b1;
    repeat (25) @(negedge clk);
    check(coreRst == 1'b1, "R7 held while pin low", int'(coreRst), 1);
    extLow = 1'b0;
    repeat (2) @(negedge clk);
    check(coreRst == 1'b1, "R7 still held two edges after pin high", int'(coreRst), 1);
    @(negedge clk);
    check(coreRst == 1'b0, "R7 released third edge after pin high", int'(coreRst), 0);
    repeat (3) @(negedge clk);

    // R7: pin held together with a watchdog flag -> external wins, vector 00
    expect_reset(2'b00, 0, DRV_N, 1'b0);
    @(negedge clk); extLow = 1'b1; wdogFlag = 1'b1;
    @(negedge clk); wdogFlag = 1'b0;
    repeat (20) @(negedge clk);
    check(vecSel == 2'b00, "R7 external overrides latched flag", int'(vecSel), 0);
    extLow = 1'b0;
    wait_release();
    repeat (3) @(negedge clk);

    // R3 R4: power-on with the pin held low past the delay
    porN = 1'b0; oscReady = 1'b0; extLow = 1'b1;
    repeat (2) @(negedge clk);
    check(coreRst == 1'b1 && vecSel == 2'b00, "R1 re-entered power-on", int'(coreRst), 1);
    expect_reset(2'b00, 0, 0, 1'b1);
    porN = 1'b1; oscReady = 1'b1;
    repeat (POR_N + 10) @(negedge clk);
    check(coreRst == 1'b1, "R3 held past delay while pin low", int'(coreRst), 1);
    check(pinDriveLow == 1'b0, "R4 power-on never pulls pin", int'(pinDriveLow), 0);
    extLow = 1'b0;
    repeat (2) @(negedge clk);
    check(coreRst == 1'b1, "R3 still held two edges after pin high", int'(coreRst), 1);
    @(negedge clk);
    check(coreRst == 1'b0, "R3 released third edge after pin high", int'(coreRst), 0);
    repeat (3) @(negedge clk);

    check(expQ.size() == 0, "R5 all expected resets seen", expQ.size(), 0);
    finish_run();
  end

endmodule